// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block turns single requests from an internal master into accesses on a 16-bit external bus, where the same lines carry the address first and the data afterwards. An access starts with an address phase. The controller drives the address and holds an address latch strobe high so that external logic can capture it. The strobe then drops and the bus turns around. A read or a write data phase follows, marked by its own active-low strobe, and a short recovery phase ends the access.

The requester sees a ready/valid handshake. The controller takes a new request only while it is idle. It reports completion with a one-cycle done pulse, and a read returns its data at the same time.

Accesses are either a full word or a single byte. The byte lane is chosen by address bit 0 together with an active-low high-byte-enable output. A byte read comes back in the low 8 bits of the read data, with zeros above it. The pad logic outside the block merges the split bus ports (out, enable, in) into one bidirectional bus.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the block is idle with req_ready=1, done=0, ale=0, ad_oe=0, and rd_n, wr_n and hbe_n all 1.
- R2: Every access begins with ale=1 for exactly ADDR_CYC cycles, during which ad_oe=1 and ad_out carries the address. Neither rd_n nor wr_n is low while ale is high.
- R3: The lane is encoded as follows. A word access (req_word=1) drives ad_out[0]=0 with hbe_n=0, whatever bit 0 of req_addr is. A low-byte access (req_word=0, req_addr[0]=0) drives ad_out[0]=0 with hbe_n=1. A high-byte access (req_word=0, req_addr[0]=1) drives ad_out[0]=1 with hbe_n=0. The hbe_n value is held from the address phase to the end of the access.
- R4: In a read, ad_oe is 0 in the cycle before rd_n falls and throughout the time rd_n is low. rd_n stays low for exactly STRB_CYC cycles, and the data is sampled in the last of those cycles.
- R5: In a write, ad_oe stays 1 from the address phase through the cycle after wr_n rises, and wr_n stays low for exactly STRB_CYC cycles.
- R6: Write data placement: a word write puts req_wdata on ad_out[15:0]. A low-byte write puts req_wdata[7:0] on ad_out[7:0]. A high-byte write puts req_wdata[7:0] on ad_out[15:8].
- R7: A byte read returns the selected lane (ad_in[7:0] for the low byte, ad_in[15:8] for the high byte) in rd_data[7:0], with rd_data[15:8]=0. A word read returns ad_in[15:0].
- R8: req_ready is 1 only while idle. A req_valid presented during an access is ignored: it produces no further address phase and writes nothing.
- R9: done is a single-cycle pulse, and rd_data holds the read result while done is high. A request presented in the done cycle is accepted, so ale rises in the next cycle.
- R10: done rises ADDR_CYC+TURN_CYC+STRB_CYC+HOLD_CYC+1 cycles after the cycle in which the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is accepted when valid and ready are both 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, zero-extended for bytes |
| ad_out | output | 16 | Value driven onto the shared bus |
| ad_oe | output | 1 | Bus drive enable |
| ad_in | input | 16 | Value seen on the shared bus |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| hbe_n | output | 1 | High byte enable, active low |

## Verification
The done pulse of one access and the acceptance of the next request can fall in the same cycle, because ready returns at the moment done is raised. The bench provokes this by waiting for done and presenting a read of the just-written location in that same cycle. It then judges that done lasts one cycle, that ale rises in the very next cycle, and that the read returns the freshly written word. A separate case holds req_valid high through a whole access to show that the overlap cannot occur while the controller is busy.

// File: rtl/mbc_pkg.sv
// Shared types for the multiplexed bus controller.
package mbc_pkg;
    // Access phases; one access walks ADDR -> TURN -> STRB -> HOLD.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_TURN = 3'd2,
        PH_STRB = 3'd3,
        PH_HOLD = 3'd4
    } phase_e;

    // Access width.
    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } size_e;
endpackage

// File: rtl/mbc_seq.sv
// Phase sequencer: steps one access through its four timed phases.
// Assumes every phase length parameter is at least 1.
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int ADDR_CYC = 1,
    parameter int TURN_CYC = 1,
    parameter int STRB_CYC = 2,
    parameter int HOLD_CYC = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   strb_last,
    output logic   done
);
    localparam int MAX_AT = (ADDR_CYC > TURN_CYC) ? ADDR_CYC : TURN_CYC;
    localparam int MAX_SH = (STRB_CYC > HOLD_CYC) ? STRB_CYC : HOLD_CYC;
    localparam int MAX_C  = (MAX_AT > MAX_SH) ? MAX_AT : MAX_SH;
    localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    phase_e        nxt;
    logic [CW-1:0] cnt;
    logic          cnt_zero;

    assign cnt_zero  = (cnt == '0);
    assign strb_last = (phase == PH_STRB) && cnt_zero;

    // Remaining-cycle count loaded on entering a phase.
    function automatic logic [CW-1:0] span(input phase_e p);
        case (p)
            PH_ADDR: span = CW'(ADDR_CYC - 1);
            PH_TURN: span = CW'(TURN_CYC - 1);
            PH_STRB: span = CW'(STRB_CYC - 1);
            PH_HOLD: span = CW'(HOLD_CYC - 1);
            default: span = '0;
        endcase
    endfunction

    // Next-phase selection.
    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE: if (start)    nxt = PH_ADDR;
            PH_ADDR: if (cnt_zero) nxt = PH_TURN;
            PH_TURN: if (cnt_zero) nxt = PH_STRB;
            PH_STRB: if (cnt_zero) nxt = PH_HOLD;
            PH_HOLD: if (cnt_zero) nxt = PH_IDLE;
            default:               nxt = PH_IDLE;
        endcase
    end

    // Phase, counter and done-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            phase <= nxt;
            done  <= (phase == PH_HOLD) && cnt_zero;
            if (nxt != phase) begin
                cnt <= span(nxt);
            end else if (!cnt_zero) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbc_lane.sv
// Byte-lane steering: derives A0 and high-byte enable, places write
// data on the selected lane, and extracts/zero-extends read data.
// Assumes a bus of exactly two byte lanes.
module mbc_lane
    import mbc_pkg::*;
#(
    parameter int DW = 16
) (
    input  size_e         size,
    input  logic          addr0,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_in,
    output logic          a0_bit,
    output logic          hbe_sel,
    output logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rdata_ext
);
    localparam int BW = DW / 2;

    logic hi_byte;

    assign hi_byte = (size == SZ_BYTE) && addr0;

    // Address bit 0 and high-byte enable for the three access kinds.
    always_comb begin
        a0_bit  = hi_byte;
        hbe_sel = (size == SZ_WORD) || hi_byte;
    end

    // Write-data placement on the bus lanes.
    always_comb begin
        if (size == SZ_WORD) begin
            bus_wdata = wdata;
        end else if (hi_byte) begin
            bus_wdata = {wdata[BW-1:0], {BW{1'b0}}};
        end else begin
            bus_wdata = {{BW{1'b0}}, wdata[BW-1:0]};
        end
    end

    // Read-data lane selection with zero extension.
    always_comb begin
        if (size == SZ_WORD) begin
            rdata_ext = bus_in;
        end else if (hi_byte) begin
            rdata_ext = {{BW{1'b0}}, bus_in[DW-1:BW]};
        end else begin
            rdata_ext = {{BW{1'b0}}, bus_in[BW-1:0]};
        end
    end
endmodule

// File: rtl/mux_bus_ctrl.sv
// Multiplexed address/data bus controller top. Captures a request while
// idle, sequences address, turnaround, strobe and recovery phases, and
// returns read data with a done pulse. Assumes external pads merge
// ad_out/ad_oe/ad_in into one bidirectional bus and no wait states.
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int DW       = 16,
    parameter int ADDR_CYC = 1,
    parameter int TURN_CYC = 1,
    parameter int STRB_CYC = 2,
    parameter int HOLD_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_word,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_in,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          hbe_n
);
    phase_e        phase;
    logic          strb_last;
    logic          accept;
    logic          r_write;
    size_e         r_size;
    logic [DW-1:0] r_addr;
    logic [DW-1:0] r_wdata;
    logic          a0_bit;
    logic          hbe_sel;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] rdata_ext;
    logic          data_drive;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_size  <= SZ_BYTE;
            r_addr  <= '0;
            r_wdata <= '0;
        end else if (accept) begin
            r_write <= req_write;
            r_size  <= req_word ? SZ_WORD : SZ_BYTE;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
        end
    end

    mbc_seq #(
        .ADDR_CYC (ADDR_CYC),
        .TURN_CYC (TURN_CYC),
        .STRB_CYC (STRB_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .phase     (phase),
        .strb_last (strb_last),
        .done      (done)
    );

    mbc_lane #(.DW(DW)) u_lane (
        .size      (r_size),
        .addr0     (r_addr[0]),
        .wdata     (r_wdata),
        .bus_in    (ad_in),
        .a0_bit    (a0_bit),
        .hbe_sel   (hbe_sel),
        .bus_wdata (bus_wdata),
        .rdata_ext (rdata_ext)
    );

    // Read data capture at the end of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (strb_last && !r_write) begin
            rd_data <= rdata_ext;
        end
    end

    assign data_drive = r_write &&
                        (phase == PH_TURN || phase == PH_STRB || phase == PH_HOLD);

    // Bus pin decode from the current phase.
    always_comb begin
        ale   = (phase == PH_ADDR);
        ad_oe = ale || data_drive;
        rd_n  = !((phase == PH_STRB) && !r_write);
        wr_n  = !((phase == PH_STRB) && r_write);
        hbe_n = !((phase != PH_IDLE) && hbe_sel);
        if (ale) begin
            ad_out = {r_addr[DW-1:1], a0_bit};
        end else if (data_drive) begin
            ad_out = bus_wdata;
        end else begin
            ad_out = '0;
        end
    end
endmodule

// File: rtl/mbc_checker.sv
// Protocol checker for mux_bus_ctrl, bound to every instance.
module mbc_checker #(
    parameter int DW       = 16,
    parameter int STRB_CYC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic [DW-1:0] ad_out,
    input logic          ad_oe,
    input logic          ale,
    input logic          rd_n,
    input logic          wr_n,
    input logic          hbe_n
);
    logic [7:0] low_run;

    // Counts consecutive cycles with either strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_run <= '0;
        else if (!rd_n || !wr_n)   low_run <= low_run + 1'b1;
        else                       low_run <= '0;
    end

    a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && ad_oe));
    a_r3_lane_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && ad_out[0]) |-> !hbe_n);
    a_r4_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    a_r4_turn_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(ad_oe));
    a_r4_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> (low_run == 8'(STRB_CYC)));
    a_r5_drive_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);
    a_r5_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe);
    a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && rd_n && wr_n && hbe_n));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind mux_bus_ctrl mbc_checker #(
    .DW       (DW),
    .STRB_CYC (STRB_CYC)
) u_mbc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .hbe_n     (hbe_n)
);

// File: tb/test_mux_bus_ctrl.sv
module test_mux_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int A_C = 1, T_C = 1, S_C = 2, H_C = 1;
    localparam int LAT = A_C + T_C + S_C + H_C + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, done, ad_oe, ale, rd_n, wr_n, hbe_n;
    logic [15:0] rd_data, ad_out, ad_in;

    int errors = 0;
    int checks = 0;

    logic [15:0] mem [256];
    logic [15:0] lat_addr = '0;
    logic        lat_hbe_n = 1'b1;

    int          m_lat, m_ale, m_strb, m_a0, m_hbe_n, m_bad;
    logic [15:0] m_rdata;

    mux_bus_ctrl #(.DW(16), .ADDR_CYC(A_C), .TURN_CYC(T_C),
                   .STRB_CYC(S_C), .HOLD_CYC(H_C)) i_mux_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .hbe_n(hbe_n));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // External memory model: latches the address on ale, writes lanes on wr_n.
    assign ad_in = rd_n ? 16'hA5A5 : mem[lat_addr[8:1]];
    always @(negedge clk) begin
        if (ale) begin
            lat_addr  <= ad_out;
            lat_hbe_n <= hbe_n;
        end
        if (!wr_n) begin
            if (!lat_hbe_n)   mem[lat_addr[8:1]][15:8] <= ad_out[15:8];
            if (!lat_addr[0]) mem[lat_addr[8:1]][7:0]  <= ad_out[7:0];
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access; keep_valid holds req_valid up (with other data) until done.
    task automatic access(input logic wr, input logic word, input logic [15:0] addr,
                          input logic [15:0] wd, input logic keep_valid);
        logic [15:0] exp_bus;
        m_lat = 0; m_ale = 0; m_strb = 0; m_bad = 0; m_a0 = 0; m_hbe_n = 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = word;
        req_addr = addr; req_wdata = wd;
        if (word)         exp_bus = wd;
        else if (addr[0]) exp_bus = {wd[7:0], 8'h00};
        else              exp_bus = {8'h00, wd[7:0]};
        do begin
            @(negedge clk);
            m_lat++;
            if (keep_valid) begin
                req_write = 1'b1; req_word = 1'b1;
                req_addr = 16'h0040; req_wdata = 16'hFFFF;
            end else begin
                req_valid = 1'b0;
            end
            if (ale) begin
                m_ale++; m_a0 = ad_out[0]; m_hbe_n = hbe_n;
            end
            if (!rd_n || !wr_n) m_strb++;
            if (!rd_n && ad_oe) m_bad++;
            if (!wr_n && (!ad_oe || ad_out != exp_bus)) m_bad++;
            if (!done && req_ready) m_bad++;
        end while (!done && m_lat < 50);
        req_valid = 1'b0;
        m_rdata = rd_data;
    endtask

    task automatic t_reset;
        chk(req_ready && !done && !ale && !ad_oe && rd_n && wr_n && hbe_n,
            "R1 reset state", {req_ready, done, ale, ad_oe, rd_n, wr_n, hbe_n}, 7'b1000111);
    endtask

    task automatic t_word;
        access(1'b1, 1'b1, 16'h0010, 16'h1234, 1'b0);
        chk(m_ale == A_C, "R2 ale cycles", m_ale, A_C);
        chk(m_a0 == 0 && m_hbe_n == 0, "R3 word lanes", {m_a0[0], m_hbe_n[0]}, 0);
        chk(m_strb == S_C && m_bad == 0, "R5 write strobe/data", m_strb, S_C);
        chk(m_lat == LAT, "R10 write latency", m_lat, LAT);
        access(1'b0, 1'b1, 16'h0010, 16'h0000, 1'b0);
        chk(m_rdata == 16'h1234, "R7 word read", m_rdata, 16'h1234);
        chk(m_strb == S_C && m_bad == 0, "R4 read strobe/release", m_strb, S_C);
        chk(m_lat == LAT, "R10 read latency", m_lat, LAT);
    endtask

    task automatic t_bytes;
        access(1'b1, 1'b0, 16'h0021, 16'h55AB, 1'b0);
        chk(m_a0 == 1 && m_hbe_n == 0 && m_bad == 0, "R6 high byte write",
            {m_a0[0], m_hbe_n[0]}, 2'b10);
        access(1'b1, 1'b0, 16'h0020, 16'h66CD, 1'b0);
        chk(m_a0 == 0 && m_hbe_n == 1 && m_bad == 0, "R6 low byte write",
            {m_a0[0], m_hbe_n[0]}, 2'b01);
        access(1'b0, 1'b1, 16'h0020, 16'h0000, 1'b0);
        chk(m_rdata == 16'hABCD, "R6 merged word", m_rdata, 16'hABCD);
        access(1'b0, 1'b0, 16'h0021, 16'h0000, 1'b0);
        chk(m_rdata == 16'h00AB, "R7 high byte read", m_rdata, 16'h00AB);
        chk(m_a0 == 1 && m_hbe_n == 0, "R3 high byte lanes", {m_a0[0], m_hbe_n[0]}, 2'b10);
        access(1'b0, 1'b0, 16'h0020, 16'h0000, 1'b0);
        chk(m_rdata == 16'h00CD, "R7 low byte read", m_rdata, 16'h00CD);
        chk(m_a0 == 0 && m_hbe_n == 1, "R3 low byte lanes", {m_a0[0], m_hbe_n[0]}, 2'b01);
        access(1'b0, 1'b1, 16'h0021, 16'h0000, 1'b0);
        chk(m_a0 == 0 && m_rdata == 16'hABCD, "R3 odd word forces A0=0", m_rdata, 16'hABCD);
    endtask

    task automatic t_busy;
        access(1'b1, 1'b1, 16'h0030, 16'hBEEF, 1'b1);
        chk(m_ale == A_C && m_bad == 0, "R8 busy request ignored", m_ale, A_C);
        access(1'b0, 1'b1, 16'h0040, 16'h0000, 1'b0);
        chk(m_rdata == 16'h0000, "R8 no stray write", m_rdata, 0);
    endtask

    task automatic t_back2back;
        access(1'b1, 1'b1, 16'h0050, 16'hC0DE, 1'b0);
        chk(done && req_ready, "R9 ready in done cycle", {done, req_ready}, 2'b11);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 16'h0050;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale && !done, "R9 accepted in done cycle", {ale, done}, 2'b10);
        m_lat = 1;
        while (!done && m_lat < 50) begin
            @(negedge clk);
            m_lat++;
        end
        chk(rd_data == 16'hC0DE, "R9 back-to-back read", rd_data, 16'hC0DE);
        chk(m_lat == LAT, "R10 back-to-back latency", m_lat, LAT);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_word;
        t_bytes;
        t_busy;
        t_back2back;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule